// File: doc/BRIEF.md
# SPI Event Interrupt Status and Clear Unit

This block gathers four single-cycle event pulses from an SPI shift engine (frame sent, frame received, receive overflow, transmit underrun) and holds each in a sticky raw status bit. Each raw bit is gated by its own enable bit, taken from a control word, to form a masked status. The OR of the masked status drives one level-sensitive interrupt line toward the processor.

Software reaches the block over a plain read/write strobe bus. It can read the raw view and the masked view at separate addresses and acknowledges events by writing ones to a clear register. The enable bits sit in the upper nibble of the low control byte, so their positions differ from the positions of the events they gate.

Top module: `spi_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, all raw status bits are 0, the masked status reads 0 and `irq_o` is low.
- R2: An event pulse sets its raw bit on the next clock edge, at the bit position for that event: sent = bit 0, received = bit 1, overflow = bit 2, underrun = bit 3. The bit stays set after the pulse ends.
- R3: Raw bits latch whether or not their enable bit is set.
- R4: Reading offset 0x24 returns the raw status in bits 3:0 with zeros above them. Reading offset 0x20 returns the masked status in bits 3:0 with zeros above them.
- R5: The masked status bit for an event is its raw bit ANDed with its enable bit. The enables sit in the control word at these positions: received at bit 4, sent at bit 5, overflow at bit 6, underrun at bit 7.
- R6: A write to offset 0x0C clears, on the next clock edge, each raw bit whose data bit is 1. Raw bits whose data bit is 0 keep their value.
- R7: A write to any other offset, or a read of any offset, leaves the raw status unchanged.
- R8: If an event pulse arrives in the same cycle as a clear of that bit, the bit is 1 after the clock edge.
- R9: `irq_o` is high exactly when the masked status is nonzero. It stays high until the set bits are cleared or disabled.
- R10: Read data is combinational from the current state. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ev_sent_i | input | 1 | Frame-sent pulse |
| ev_rcvd_i | input | 1 | Frame-received pulse |
| ev_ovf_i | input | 1 | Receive overflow pulse |
| ev_unf_i | input | 1 | Transmit underrun pulse |
| ctrl_word_i | input | 32 | Control word that carries the enable bits |
| bus_addr_i | input | 8 | Byte offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt |

## Verification
A raw bit that is stuck or lost shows up at offset 0x24 in the cycle after the pulse or clear that should have changed it. The same fault reaches `irq_o` in that cycle, as long as the bit is enabled. An enable taken from the wrong bit position shows up as a masked view at 0x20 that does not match the bench's own AND of raw and control bits, and this appears without any clock delay. A wrong priority between event and clear is only visible in the cycle right after the two collide, so the bench reads the raw view exactly there.

// File: rtl/spi_irq_pkg.sv
// Package: shared widths, event indices and register offsets for the
// SPI interrupt unit. Assumes byte offsets on an 8-bit address bus.
package spi_irq_pkg;
    localparam int NUM_EV   = 4;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;

    // Event bit positions in the status views (decoded by software)
    localparam int EV_SENT  = 0;
    localparam int EV_RCVD  = 1;
    localparam int EV_OVF   = 2;
    localparam int EV_UNF   = 3;

    // Enable bit positions inside the control word
    localparam int EN_RCVD  = 4;
    localparam int EN_SENT  = 5;
    localparam int EN_OVF   = 6;
    localparam int EN_UNF   = 7;

    localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_MASKED = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 8'h24;

    typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/spi_irq_enmap.sv
// Module: reorders the enable bits of the control word into event order.
// Assumes the control word is held stable by its owner; purely combinational.
module spi_irq_enmap
    import spi_irq_pkg::*;
#(
    parameter int CTRL_W = DATA_W
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    output ev_vec_t           en_o
);
    // Pick each event's enable from its control-word position
    always_comb begin
        en_o          = '0;
        en_o[EV_SENT] = ctrl_i[EN_SENT];
        en_o[EV_RCVD] = ctrl_i[EN_RCVD];
        en_o[EV_OVF]  = ctrl_i[EN_OVF];
        en_o[EV_UNF]  = ctrl_i[EN_UNF];
    end
endmodule

// File: rtl/spi_irq_raw.sv
// Module: sticky raw event bits with write-one-to-clear.
// Assumes events are single-cycle pulses; a set in the same cycle wins over a clear.
module spi_irq_raw
    import spi_irq_pkg::*;
#(
    parameter int N = NUM_EV
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] raw_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // Hold one event bit: the set wins, otherwise clear or keep
        always_ff @(posedge clk_i) begin
            if (!rst_ni)        raw_o[g] <= 1'b0;
            else if (set_i[g])  raw_o[g] <= 1'b1;
            else if (clr_i[g])  raw_o[g] <= 1'b0;
        end

        assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[g] |=> raw_o[g]);
        assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (raw_o[g] && !clr_i[g]) |=> raw_o[g]);
        assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[g] && !set_i[g]) |=> !raw_o[g]);
    end
endmodule

// File: rtl/spi_irq_bus.sv
// Module: bus decoder; makes clear strobes and muxes read data.
// Assumes single-cycle strobes; reads are combinational and have no side effects.
module spi_irq_bus
    import spi_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  ev_vec_t           raw_i,
    input  ev_vec_t           masked_i,
    output ev_vec_t           clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    // Build the clear strobes from a write to the clear offset
    always_comb begin
        clr_o = '0;
        if (wr_i && addr_i == OFF_CLEAR) clr_o = wdata_i[NUM_EV-1:0];
    end

    // Select read data by offset; unmapped offsets read zero
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFF_MASKED: rdata_o[NUM_EV-1:0] = masked_i;
            OFF_RAW:    rdata_o[NUM_EV-1:0] = raw_i;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/spi_irq_unit.sv
// Top: SPI interrupt status and clear unit. Collects event pulses into
// raw bits, masks them with control-word enables, and drives a level irq.
// Assumes the read strobe is informative only (reads have no side effects).
module spi_irq_unit
    import spi_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ev_sent_i,
    input  logic              ev_rcvd_i,
    input  logic              ev_ovf_i,
    input  logic              ev_unf_i,
    input  logic [DATA_W-1:0] ctrl_word_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    ev_vec_t ev_set, ev_clr, ev_raw, ev_en, ev_masked;
    logic    rd_unused;

    // Gather event pulses into event order
    always_comb begin
        ev_set          = '0;
        ev_set[EV_SENT] = ev_sent_i;
        ev_set[EV_RCVD] = ev_rcvd_i;
        ev_set[EV_OVF]  = ev_ovf_i;
        ev_set[EV_UNF]  = ev_unf_i;
    end

    assign rd_unused = bus_rd_i;

    spi_irq_enmap #(.CTRL_W(DATA_W)) i_enmap (
        .ctrl_i (ctrl_word_i),
        .en_o   (ev_en)
    );

    spi_irq_raw #(.N(NUM_EV)) i_raw (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (ev_set),
        .clr_i  (ev_clr),
        .raw_o  (ev_raw)
    );

    // Gate raw bits with their enables
    assign ev_masked = ev_raw & ev_en;

    spi_irq_bus i_bus (
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .wdata_i  (bus_wdata_i),
        .raw_i    (ev_raw),
        .masked_i (ev_masked),
        .clr_o    (ev_clr),
        .rdata_o  (bus_rdata_o)
    );

    // Level interrupt from any pending masked event
    assign irq_o = |ev_masked;

    assert_irq_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (|(ev_raw & {ctrl_word_i[EN_UNF], ctrl_word_i[EN_OVF],
                              ctrl_word_i[EN_RCVD], ctrl_word_i[EN_SENT]})));
    assert_other_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(bus_wr_i && bus_addr_i == OFF_CLEAR) && ev_set == '0) |=> $stable(ev_raw));
    assert_event_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_unf_i |=> ev_raw[EV_UNF]);
    assert_reset_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (ev_raw == '0 && !irq_o));
endmodule

// File: tb/test_spi_irq_unit.sv
module test_spi_irq_unit;
    logic        clk = 0, rst_n = 0;
    logic        e_s = 0, e_r = 0, e_o = 0, e_u = 0;
    logic [31:0] ctrl = 0, wdata = 0, rdata;
    logic [7:0]  addr = 0;
    logic        wr = 0, rd = 0, irq;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    spi_irq_unit i_spi_irq_unit (
        .clk_i(clk), .rst_ni(rst_n), .ev_sent_i(e_s), .ev_rcvd_i(e_r),
        .ev_ovf_i(e_o), .ev_unf_i(e_u), .ctrl_word_i(ctrl),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read an offset combinationally, away from the clock edge
    task automatic rd_at(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd = 1; #1; d = rdata; rd = 0;
    endtask

    // One cycle of stimulus: drive after negedge, hold over posedge
    task automatic pulse(logic [3:0] ev, logic w, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        {e_u, e_o, e_r, e_s} = ev; wr = w; addr = a; wdata = d;
        @(negedge clk);
        {e_u, e_o, e_r, e_s} = 0; wr = 0; wdata = 0;
    endtask

    function automatic logic [3:0] mask_of(logic [31:0] c, logic [3:0] r);
        return r & {c[7], c[6], c[4], c[5]};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        ctrl = 32'hF0;
        rd_at(8'h24, d); chk("R1 raw", d, 0);
        rd_at(8'h20, d); chk("R1 masked", d, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        ctrl = 0;
        pulse(4'b0001, 0, 0, 0);
        rd_at(8'h24, d); chk("R2 sent bit0 sticky", d, 32'h1);
        chk("R3 irq with no enables", irq, 0);
        pulse(4'b1000, 0, 0, 0);
        rd_at(8'h24, d); chk("R3 underrun latched disabled", d, 32'h9);
        pulse(4'b0110, 0, 0, 0);
        rd_at(8'h24, d); chk("R2 all four", d, 32'hF);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            ctrl = 32'h10 << i; #1;
            rd_at(8'h20, d); chk("R5 masked single enable", d, {28'h0, mask_of(ctrl, 4'hF)});
            chk("R9 irq single enable", irq, 1);
        end
        ctrl = 32'h20; pulse(4'b0000, 1, 8'h0C, 32'h1);
        rd_at(8'h20, d); chk("R5 sent enable bit5", d, 0);
        chk("R9 irq drops after clear", irq, 0);
        ctrl = 32'hFFFF_FF0F; #1;
        rd_at(8'h20, d); chk("R5 other ctrl bits ignored", d, 0);
        rd_at(8'h24, d); chk("R4 raw upper zero", d, 32'hE);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        pulse(4'b0000, 1, 8'h0C, 32'hFFFF_FFF4);
        rd_at(8'h24, d); chk("R6 clear bit2 only", d, 32'hA);
        pulse(4'b0000, 1, 8'h24, 32'hF);
        rd_at(8'h24, d); chk("R7 write raw offset no effect", d, 32'hA);
        pulse(4'b0000, 1, 8'h20, 32'hF);
        rd_at(8'h24, d); chk("R7 write masked offset no effect", d, 32'hA);
        pulse(4'b0000, 0, 8'h0C, 32'hF);
        rd_at(8'h24, d); chk("R7 read of clear offset no effect", d, 32'hA);
        pulse(4'b0010, 1, 8'h0C, 32'hA);
        rd_at(8'h24, d); chk("R8 set wins over clear", d, 32'h2);
        ctrl = 32'h10; #1;
        chk("R9 irq level held", irq, 1);
        repeat (3) @(negedge clk);
        chk("R9 irq still held", irq, 1);
        pulse(4'b0000, 1, 8'h0C, 32'h2);
        chk("R9 irq cleared", irq, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        pulse(4'b1111, 0, 0, 0);
        rd_at(8'h00, d); chk("R10 unmapped 0x00", d, 0);
        rd_at(8'h0C, d); chk("R10 clear offset reads zero", d, 0);
        rd_at(8'h28, d); chk("R10 unmapped 0x28", d, 0);
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        rd_at(8'h24, d); chk("R1 raw after re-reset", d, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                t_reset(); t_latch(); t_mask(); t_clear(); t_unmapped();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule